// File: doc/BRIEF.md
# Feedback Divider Ramp Sequencer

This block changes the feedback divider N of a PLL that is already running. It does not step N in one jump. It sets up the PLL's own slow ramp hardware, writes the new N, enables the ramp, and waits for the ramp to report completion. It drives a set of register-style outputs: two step-rate coefficients, a slowdown-mode flag, the coefficient word, and a ramp-enable flag. It reads back a status input, already synchronized, that signals ramp completion. All waits are counted in microsecond ticks. A prescaler makes these ticks by dividing the clock by `TICK_DIV`.

A request is a one-cycle `start` pulse with `target_n`. If `target_n` already equals the programmed N, the block only pulses `done`. Otherwise the FSM runs through its states in order:

- **IDLE → WAIT_N** on an accepted start. On this transition it loads the step coefficients and enters slowdown mode.
- **WAIT_N → WAIT_EN** on the next tick. On this transition it writes N.
- **WAIT_EN → POLL** on the next tick. On this transition it sets ramp-enable.
- **POLL → IDLE** on the tick where the status input is seen high, or on the last allowed poll. On this transition it clears slowdown and ramp-enable together, pulses `done`, and pulses `timeout` if completion was never seen.

Top module: `ndiv_ramp_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `timeout`, `slowdown` and `ramp_en` are 0, both step coefficients are 0, and the N field equals `N_INIT`.
- R2: A start whose `target_n` equals the programmed N gives a `done` pulse in the cycle after start. `timeout` stays 0, `busy` stays 0, and the step coefficients, `slowdown`, `ramp_en` and N all keep their values.
- R3: On an accepted start (different N), at the same clock edge: `step_a` becomes 0x2B, `step_b` becomes 0x0B, `slowdown` rises and `busy` rises.
- R4: Exactly `TICK_DIV` cycles after the accepted start, the N field takes the target. `coeff_word` is laid out as PL in bits 21:16, N in bits 15:8 and M in bits 7:0. PL and M are passed through from `pl_in` and `m_in`. N changes only while `slowdown` is 1 and `ramp_en` is 0.
- R5: `ramp_en` rises exactly `TICK_DIV` cycles after the N write, while `slowdown` is 1.
- R6: `ramp_done_sync` is sampled once per tick, starting one tick after ramp-enable. If it is first seen high at poll k, the operation ends (2+k)·`TICK_DIV` cycles after start.
- R7: At the end of an operation, `slowdown` and `ramp_en` fall at the same edge, `busy` falls, and `done` is high for exactly that one cycle.
- R8: If `MAX_POLLS` polls pass without completion, the operation ends at (2+`MAX_POLLS`)·`TICK_DIV` cycles after start, with `timeout` pulsed together with `done`.
- R9: A start while `busy` is 1 is ignored. The timeline and the N written are those of the operation already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse |
| target_n | input | N_W | Requested feedback divider |
| m_in | input | M_W | Reference divider, passed into the coefficient word |
| pl_in | input | PL_W | Post divider, passed into the coefficient word |
| ramp_done_sync | input | 1 | Synchronized ramp-complete status |
| step_a | output | 8 | Step coefficient A |
| step_b | output | 8 | Step coefficient B |
| slowdown | output | 1 | Slowdown-mode flag |
| ramp_en | output | 1 | Dynamic ramp enable |
| coeff_word | output | PL_W+N_W+M_W | {PL, N, M} coefficient word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | One-cycle timeout pulse, coincident with done |

## Verification
Every output is registered, so each result appears one edge after the event that causes it:

- The skip `done` appears at edge 0, the edge that accepts start.
- The N write appears at edge T.
- Ramp-enable appears at edge 2T.
- The end of the operation appears at edge (2+k)·T.

Here T is `TICK_DIV`. The bench counts edges from the start edge and samples every output at each falling edge up to the expected end. It compares against a timeline computed from T, the poll at which it raises the status input, and `MAX_POLLS`. It raises the status input one falling edge before the intended poll edge.

// File: rtl/ndr_pkg.sv
package ndr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_N  = 2'd1,
        ST_WAIT_EN = 2'd2,
        ST_POLL    = 2'd3
    } ndr_state_e;

    localparam logic [7:0] STEP_A_VAL = 8'h2B;
    localparam logic [7:0] STEP_B_VAL = 8'h0B;
endpackage

// File: rtl/ndr_tick.sv
module ndr_tick #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ndr_poll_cnt.sv
module ndr_poll_cnt #(
    parameter int MAX = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic inc,
    output logic last
);
    localparam int PW = $clog2(MAX + 1);
    localparam logic [PW-1:0] LAST = PW'(MAX - 1);

    logic [PW-1:0] cnt_q;

    assign last = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (reload)
            cnt_q <= '0;
        else if (inc && !last)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ndiv_ramp_ctrl.sv
module ndiv_ramp_ctrl
    import ndr_pkg::*;
#(
    parameter int TICK_DIV  = 100,
    parameter int MAX_POLLS = 500,
    parameter int M_W       = 8,
    parameter int N_W       = 8,
    parameter int PL_W      = 6,
    parameter int N_INIT    = 40
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [N_W-1:0]            target_n,
    input  logic [M_W-1:0]            m_in,
    input  logic [PL_W-1:0]           pl_in,
    input  logic                      ramp_done_sync,
    output logic [7:0]                step_a,
    output logic [7:0]                step_b,
    output logic                      slowdown,
    output logic                      ramp_en,
    output logic [PL_W+N_W+M_W-1:0]   coeff_word,
    output logic                      busy,
    output logic                      done,
    output logic                      timeout
);
    ndr_state_e state_q, state_d;

    logic [N_W-1:0] n_q, tgt_q;
    logic           tick, last_poll;
    logic           accept, skip, finish;

    assign accept = (state_q == ST_IDLE) && start && (target_n != n_q);
    assign skip   = (state_q == ST_IDLE) && start && (target_n == n_q);
    assign finish = (state_q == ST_POLL) && tick && (ramp_done_sync || last_poll);

    ndr_tick #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .tick  (tick)
    );

    ndr_poll_cnt #(.MAX(MAX_POLLS)) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (accept),
        .inc    ((state_q == ST_POLL) && tick),
        .last   (last_poll)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_WAIT_N;
            ST_WAIT_N:  if (tick)   state_d = ST_WAIT_EN;
            ST_WAIT_EN: if (tick)   state_d = ST_POLL;
            ST_POLL:    if (finish) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_a   <= '0;
            step_b   <= '0;
            slowdown <= 1'b0;
            ramp_en  <= 1'b0;
            n_q      <= N_W'(N_INIT);
            tgt_q    <= N_W'(N_INIT);
            done     <= 1'b0;
            timeout  <= 1'b0;
        end else begin
            done    <= skip || finish;
            timeout <= finish && !ramp_done_sync;
            if (accept) begin
                step_a   <= STEP_A_VAL;
                step_b   <= STEP_B_VAL;
                slowdown <= 1'b1;
                tgt_q    <= target_n;
            end
            if ((state_q == ST_WAIT_N) && tick)
                n_q <= tgt_q;
            if ((state_q == ST_WAIT_EN) && tick)
                ramp_en <= 1'b1;
            if (finish) begin
                slowdown <= 1'b0;
                ramp_en  <= 1'b0;
            end
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign coeff_word = {pl_in, n_q, m_in};
endmodule

// File: rtl/ndiv_ramp_ctrl_chk.sv
module ndiv_ramp_ctrl_chk #(
    parameter int N_W = 8,
    parameter int CW  = 22,
    parameter int M_W = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [7:0]    step_a,
    input logic [7:0]    step_b,
    input logic          slowdown,
    input logic          ramp_en,
    input logic [CW-1:0] coeff_word,
    input logic          busy,
    input logic          done,
    input logic          timeout
);
    logic [N_W-1:0] n_fld;
    assign n_fld = coeff_word[M_W +: N_W];

    p_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slowdown) |-> (step_a == 8'h2B && step_b == 8'h0B && busy));

    p_nwrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(n_fld) |-> (slowdown && !ramp_en));

    p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ramp_en) |-> slowdown);

    p_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slowdown) |-> (!ramp_en && done && !busy));

    p_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done);

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!slowdown && !ramp_en));
endmodule

bind ndiv_ramp_ctrl ndiv_ramp_ctrl_chk #(
    .N_W (N_W),
    .CW  (PL_W + N_W + M_W),
    .M_W (M_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_a     (step_a),
    .step_b     (step_b),
    .slowdown   (slowdown),
    .ramp_en    (ramp_en),
    .coeff_word (coeff_word),
    .busy       (busy),
    .done       (done),
    .timeout    (timeout)
);

// File: tb/ndiv_ramp_ctrl_bench.sv
module ndiv_ramp_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TCK        = 3;
    localparam int MAXP       = 20;
    localparam int NINIT      = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  target_n = '0;
    logic [7:0]  m_in = 8'd2;
    logic [5:0]  pl_in = 6'd1;
    logic        ramp_done_sync = 1'b0;
    logic [7:0]  step_a, step_b;
    logic        slowdown, ramp_en, busy, done, timeout;
    logic [21:0] coeff_word;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [7:0] exp_n = 8'(NINIT);
    logic [7:0] exp_step_a = 8'h00;
    logic [7:0] exp_step_b = 8'h00;

    ndiv_ramp_ctrl #(.TICK_DIV(TCK), .MAX_POLLS(MAXP), .N_INIT(NINIT)) u_ndiv_ramp_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .target_n(target_n),
        .m_in(m_in), .pl_in(pl_in), .ramp_done_sync(ramp_done_sync),
        .step_a(step_a), .step_b(step_b), .slowdown(slowdown), .ramp_en(ramp_en),
        .coeff_word(coeff_word), .busy(busy), .done(done), .timeout(timeout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run did not finish act=%0d exp<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h at t=%0t", tag, act, expv, $time);
        end
    endtask

    function automatic int end_cycle(input bit same, input int d);
        if (same) return 0;
        return (2 + ((d > MAXP) ? MAXP : d)) * TCK;
    endfunction

    task automatic run_op(input logic [7:0] nn, input int d, input int glitch);
        bit same;
        int endc;
        logic [7:0] old_n, cur_n;
        same  = (nn == exp_n);
        endc  = end_cycle(same, d);
        old_n = exp_n;
        @(negedge clk);
        target_n = nn;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!same) begin
            exp_step_a = 8'h2B;
            exp_step_b = 8'h0B;
        end
        for (int c = 0; c <= endc; c++) begin
            cur_n = (!same && c >= TCK) ? nn : old_n;
            if (same) begin
                chk("R2 done", done, 1);
                chk("R2 timeout", timeout, 0);
                chk("R2 busy", busy, 0);
                chk("R2 step_a", step_a, exp_step_a);
                chk("R2 step_b", step_b, exp_step_b);
                chk("R2 slowdown", slowdown, 0);
                chk("R2 ramp_en", ramp_en, 0);
            end else begin
                if (c == 0) begin
                    chk("R3 step_a", step_a, 8'h2B);
                    chk("R3 step_b", step_b, 8'h0B);
                end
                chk("R3 R7 slowdown", slowdown, (c < endc) ? 1 : 0);
                chk("R3 R7 busy", busy, (c < endc) ? 1 : 0);
                chk("R5 R7 ramp_en", ramp_en, (c >= 2*TCK && c < endc) ? 1 : 0);
                chk("R6 R7 done", done, (c == endc) ? 1 : 0);
                chk("R8 timeout", timeout, (c == endc && d > MAXP) ? 1 : 0);
            end
            chk("R4 R9 coeff_word", coeff_word, {pl_in, cur_n, m_in});
            ramp_done_sync = !same && (c + 1 >= (2 + d) * TCK) && (c < endc);
            start = (c == glitch) && (c < endc);
            if (c == glitch) target_n = ~nn;
            @(negedge clk);
        end
        ramp_done_sync = 1'b0;
        start = 1'b0;
        chk("R7 done one cycle", done, 0);
        exp_n = same ? old_n : nn;
    endtask

    initial begin
        logic [7:0] rn;
        void'($urandom(32'd1234));
        #(CLK_PERIOD * 2 + 1);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 timeout", timeout, 0);
        chk("R1 slowdown", slowdown, 0);
        chk("R1 ramp_en", ramp_en, 0);
        chk("R1 step_a", step_a, 0);
        chk("R1 step_b", step_b, 0);
        chk("R1 n field", coeff_word[15:8], NINIT);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(8'(NINIT), 0, -1);    // R2 before any ramp: steps stay 0
        run_op(8'd60, 1, -1);        // R6 done at first poll
        run_op(8'd61, MAXP, -1);     // R6 done at last poll
        run_op(8'd62, MAXP + 5, -1); // R8 timeout
        run_op(8'd63, 4, 8);         // R9 start while busy
        run_op(8'd63, 0, -1);        // R2 after ramps
        for (int i = 0; i < 30; i++) begin
            rn    = 8'($urandom_range(8, 255));
            m_in  = 8'($urandom_range(1, 255));
            pl_in = 6'($urandom_range(0, 14));
            run_op(rn, $urandom_range(1, MAXP + 3), (i % 4 == 0) ? 2*TCK + 1 : -1);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule